// File: doc/BRIEF.md
# Heartbeat Watchdog with Supply-Low Indication

This block supervises a processor by watching a heartbeat line that software toggles while it runs normally. Every rising or falling edge of the heartbeat restarts an idle counter. When the counter reaches the programmed timeout with no edge seen, an active-low alarm output drops. The alarm is meant for a non-maskable interrupt line. It stays low until activity resumes, the system reset generator asserts its reset, or the heartbeat driver lets go of the line.

Two conditions hold the idle counter at zero and leave the watchdog inactive. The first is an active reset from the reset generator. The second is a heartbeat that nobody drives; a separate enable flag reports this condition. The alarm output also doubles as a low-line indicator. While the supply-low flag is set, the output is forced low combinationally. It comes back high the moment the flag clears, with no minimum width. With the heartbeat left undriven, the output therefore follows the supply condition alone.

The controller has three states. HELD means the counter is cleared and not running. ARMED means the counter is running and the alarm is inactive. EXPIRED means the timeout was reached and the alarm is asserted. The transitions are:
- hold: from any state to HELD while reset is active or the heartbeat is undriven.
- arm: from HELD to ARMED on the first cycle free of hold.
- expire: from ARMED to EXPIRED when the count is one short of the limit and no edge arrives.
- recover: from EXPIRED to ARMED on a heartbeat edge.
- An edge in ARMED keeps the state and clears the count.

The heartbeat must already be synchronized to `clk`. The clock period must be shorter than the shortest heartbeat pulse so that the pulse is sampled at least once. `TIMEOUT_CYC` must be at least 2.

Top module: `heartbeat_watchdog`

## Requirements
- R1: After the block reset `rst_n` is released, with `supply_low` = 0, `wdog_n` is 1.
- R2: Suppose the heartbeat is driven, reset is inactive and no heartbeat edge occurs. Then `wdog_n` goes to 0 on the `TIMEOUT_CYC`-th rising clock edge counted from the first edge of the quiet period. A quiet edge is one where hold is false and no edge is seen.
- R3: A rising or falling heartbeat level change clears the count, with 0 meaning no idle time. Such a change is a `hb_level` value different from the previous cycle's value while `hb_driven` was 1 in both cycles. A full `TIMEOUT_CYC` quiet edges must then pass again before `wdog_n` falls.
- R4: Once `wdog_n` is low because of a timeout, it stays low until an edge, a reset or an undriven heartbeat. After a heartbeat edge it is high again following the next clock edge.
- R5: While `sys_reset_active` is 1, the counter is held at zero and `wdog_n` is 1 one clock edge later, unless `supply_low` is set. Counting begins at the first clock edge after release.
- R6: While `hb_driven` is 0, the counter is held at zero and `wdog_n` is 1 one clock edge later, unless `supply_low` is set. Level changes of `hb_level` while undriven have no effect.
- R7: `supply_low` = 1 drives `wdog_n` to 0 in the same cycle without a clock edge. When the flag clears, `wdog_n` returns in the same cycle to the value given by the timer state.
- R8: A heartbeat pulse one clock cycle wide produces two edges. It counts as activity and restarts the count.
- R9: When `hb_driven` goes from 0 to 1, the level difference between the new sample and the last sample taken while undriven is not treated as an edge. The timeout then expires exactly `TIMEOUT_CYC` clock edges after the enabling edge.
- R10: The idle counter saturates at `TIMEOUT_CYC` and never wraps. `wdog_n` stays low for any quiet period longer than the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| hb_level | input | 1 | Synchronized heartbeat level from the processor |
| hb_driven | input | 1 | 1 when the heartbeat line is actively driven; 0 models an undriven line |
| supply_low | input | 1 | 1 while the supply is below its threshold |
| sys_reset_active | input | 1 | 1 while the system reset generator asserts reset |
| wdog_n | output | 1 | Active-low watchdog alarm and low-line indicator |

## Verification
The bench builds the watchdog with `TIMEOUT_CYC` = 20. At that value, an expiry, the saturation hold and the recovery from EXPIRED each take only tens of cycles, so many of them fit into one short run. The small limit also lets a random mix of rare heartbeat edges, driver drop-outs, reset pulses and supply dips reach EXPIRED repeatedly. The same mix exercises the one-short-of-limit race, where an edge arrives just as the count would expire. The default of 400,000,000 cycles, which is 1.6 s at 250 MHz, only widens the counter.

// File: rtl/hbwd_pkg.sv
`timescale 1ns/1ps
package hbwd_pkg;

    typedef enum logic [1:0] {
        WD_HELD    = 2'd0,
        WD_ARMED   = 2'd1,
        WD_EXPIRED = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdg_edge_detect.sv
`timescale 1ns/1ps
module wdg_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic driven,
    output logic activity
);

    logic level_q;
    logic driven_q;

    // The previous sample is reloaded every cycle. An edge therefore only counts
    // when the line was driven in both the previous and the current cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q  <= 1'b0;
            driven_q <= 1'b0;
        end else begin
            level_q  <= level;
            driven_q <= driven;
        end
    end

    always_comb begin
        activity = driven & driven_q & (level ^ level_q);
    end

endmodule

// File: rtl/wdg_idle_timer.sv
`timescale 1ns/1ps
module wdg_idle_timer #(
    parameter int unsigned TIMEOUT_CYC = 20,
    parameter int unsigned CNT_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] idle_cnt,
    output logic             near_term
);

    localparam logic [CNT_W-1:0] TERM = CNT_W'(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (cnt_q != TERM) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    always_comb begin
        idle_cnt  = cnt_q;
        near_term = (cnt_q == LAST);
    end

endmodule

// File: rtl/heartbeat_watchdog.sv
`timescale 1ns/1ps
module heartbeat_watchdog #(
    parameter int unsigned TIMEOUT_CYC = 400_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_level,
    input  logic hb_driven,
    input  logic supply_low,
    input  logic sys_reset_active,
    output logic wdog_n
);
    import hbwd_pkg::*;

    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);

    logic             hb_act;
    logic             hold;
    logic             clear;
    logic [CNT_W-1:0] idle_cnt;
    logic             near_term;
    wd_state_e        state_q;
    wd_state_e        state_d;

    wdg_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (hb_level),
        .driven   (hb_driven),
        .activity (hb_act)
    );

    always_comb begin
        hold  = sys_reset_active | ~hb_driven;
        clear = hold | hb_act;
    end

    wdg_idle_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .idle_cnt  (idle_cnt),
        .near_term (near_term)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_HELD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (hold) begin
            state_d = WD_HELD;
        end else begin
            unique case (state_q)
                WD_HELD:    state_d = WD_ARMED;
                WD_ARMED:   if (!hb_act && near_term) state_d = WD_EXPIRED;
                WD_EXPIRED: if (hb_act) state_d = WD_ARMED;
                default:    state_d = WD_HELD;
            endcase
        end
    end

    // Output: the supply-low path is combinational so it has no delay
    always_comb begin
        wdog_n = 1'b1;
        unique case (state_q)
            WD_EXPIRED: wdog_n = 1'b0;
            default:    wdog_n = 1'b1;
        endcase
        if (supply_low) wdog_n = 1'b0;
    end

endmodule

// File: rtl/heartbeat_watchdog_chk.sv
`timescale 1ns/1ps
module heartbeat_watchdog_chk
    import hbwd_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 20,
    parameter int unsigned CNT_W       = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hb_level,
    input logic             hb_driven,
    input logic             supply_low,
    input logic             sys_reset_active,
    input logic             wdog_n,
    input wd_state_e        state,
    input logic [CNT_W-1:0] idle_cnt
);

    localparam logic [CNT_W-1:0] TERM = CNT_W'(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    assert_lowline_R7: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> !wdog_n);

    assert_reset_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_active |=> (idle_cnt == '0) && (wdog_n || supply_low));

    assert_undriven_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hb_driven |=> (idle_cnt == '0) && (state == WD_HELD));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= TERM);

    assert_expire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && state == WD_ARMED && idle_cnt == LAST && hb_driven &&
         !sys_reset_active && hb_level == $past(hb_level)) |=> state == WD_EXPIRED);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && state == WD_EXPIRED && hb_driven && !sys_reset_active &&
         hb_level == $past(hb_level)) |=> !wdog_n);

    assert_edge_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && hb_driven && $past(hb_driven) && !sys_reset_active &&
         hb_level != $past(hb_level)) |=> (idle_cnt == '0) && (wdog_n || supply_low));

endmodule

bind heartbeat_watchdog heartbeat_watchdog_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CNT_W       (CNT_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .hb_level         (hb_level),
    .hb_driven        (hb_driven),
    .supply_low       (supply_low),
    .sys_reset_active (sys_reset_active),
    .wdog_n           (wdog_n),
    .state            (state_q),
    .idle_cnt         (idle_cnt)
);

// File: tb/heartbeat_watchdog_tb.sv
`timescale 1ns/1ps
module heartbeat_watchdog_tb;

    localparam int unsigned TO = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hb_level = 1'b0;
    logic hb_driven = 1'b0;
    logic supply_low = 1'b0;
    logic sys_reset_active = 1'b0;
    logic wdog_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference state derived from the requirements
    int unsigned m_idle = 0;
    bit m_hb_q = 0;
    bit m_drv_q = 0;

    always #2 clk = ~clk;

    heartbeat_watchdog #(.TIMEOUT_CYC(TO)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .hb_level         (hb_level),
        .hb_driven        (hb_driven),
        .supply_low       (supply_low),
        .sys_reset_active (sys_reset_active),
        .wdog_n           (wdog_n)
    );

    function automatic int unsigned next_idle(int unsigned idle, bit clr);
        if (clr) return 0;
        return (idle < TO) ? idle + 1 : TO;
    endfunction

    function automatic bit exp_wdog(int unsigned idle, bit sl);
        return !(sl || idle == TO);
    endfunction

    task automatic check(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: wdog_n act=%0b exp=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock cycle: drive at the falling edge, check the combinational
    // low-line path at once, then check the registered result after the rising edge.
    task automatic step(bit hb, bit drv, bit sl, bit ra, string tag);
        bit clr;
        @(negedge clk);
        hb_level = hb;
        hb_driven = drv;
        supply_low = sl;
        sys_reset_active = ra;
        #1;
        check(tag, wdog_n, exp_wdog(m_idle, sl));
        @(posedge clk);
        clr = ra || !drv || (m_drv_q && (hb != m_hb_q));
        m_idle = next_idle(m_idle, clr);
        m_hb_q = hb;
        m_drv_q = drv;
        #1;
        check(tag, wdog_n, exp_wdog(m_idle, sl));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit hb, drv, sl, ra;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", wdog_n, 1'b1);

        // R5: reset holds the timer far beyond the timeout
        for (int i = 0; i < 3 * TO; i++) step(0, 1, 0, 1, "R5");
        // R2: quiet heartbeat expires after exactly TO edges
        for (int i = 0; i < TO + 3; i++) step(0, 1, 0, 0, "R2");
        check("R2", wdog_n, 1'b0);
        // R10: saturation keeps the alarm low
        for (int i = 0; i < 3 * TO; i++) step(0, 1, 0, 0, "R10");
        // R4: an edge recovers the alarm
        step(1, 1, 0, 0, "R4");
        check("R4", wdog_n, 1'b1);
        // R3: an edge one short of expiry restarts the count
        for (int i = 0; i < TO - 2; i++) step(1, 1, 0, 0, "R3");
        step(0, 1, 0, 0, "R3");
        for (int i = 0; i < TO + 2; i++) step(0, 1, 0, 0, "R3");
        // R8: one-cycle pulse
        step(1, 1, 0, 0, "R8");
        step(0, 1, 0, 0, "R8");
        for (int i = 0; i < TO + 2; i++) step(0, 1, 0, 0, "R8");
        // R6: undriven clears the expired alarm and ignores level changes
        for (int i = 0; i < 3 * TO; i++) step(bit'(i % 3 == 0), 0, 0, 0, "R6");
        step(1, 0, 0, 0, "R6");
        // R9: enabling with a changed level is not an edge
        step(0, 1, 0, 0, "R9");
        for (int i = 0; i < TO + 2; i++) step(0, 1, 0, 0, "R9");
        // R5: reset clears an expired alarm
        step(0, 1, 0, 1, "R5");
        check("R5", wdog_n, 1'b1);
        for (int i = 0; i < TO + 2; i++) step(0, 1, 0, 0, "R5");
        // R7: supply low overrides and releases immediately
        step(1, 1, 1, 0, "R7");
        for (int i = 0; i < 5; i++) step(1, 1, 1, 0, "R7");
        step(1, 1, 0, 0, "R7");
        for (int i = 0; i < TO + 2; i++) step(1, 1, 0, 0, "R7");
        step(1, 1, 1, 0, "R7");
        step(1, 1, 0, 0, "R7");
        step(1, 0, 1, 0, "R7");
        step(1, 0, 0, 0, "R7");

        // Random mix
        hb = 0; drv = 1; sl = 0; ra = 0;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 25 == 0) hb = !hb;
            if ($urandom % 200 == 0) drv = !drv;
            if ($urandom % 150 == 0) ra = !ra;
            if ($urandom % 100 == 0) sl = !sl;
            step(hb, drv, sl, ra, "R2");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule